// File: doc/BRIEF.md
# Replica Signature Majority Voter

This block sits on the coordinator side of a replicated system. At every checkpoint each of N replicas offers a 32-bit hardware signature together with a flag saying whether the report arrived. When the coordinator pulses `start`, the voter compares all reports pairwise. It decides whether one signature value is held by a strict majority of the replicas. It then marks every replica that either stayed silent or reported something else.

The result is registered one clock after the start pulse: the agreed signature, a majority flag, and a fault mask with one bit per replica. The result stays put until the next start pulse. A missing report is an omission fault and a differing report is a commission fault; both set the replica's mask bit. With N replicas the vote survives t faulty ones as long as N > 2t.

Top module: `sig_majority_voter`

## Requirements
- R1: The outputs change only on the rising clock edge at which `start` is sampled high, so the result is visible one clock after the pulse.
- R2: `majority_ok` is 1 exactly when one signature value is reported by more than N/2 replicas whose valid bit is 1 (three or more for the default N=5).
- R3: When `majority_ok` is 1, `agreed_sig` equals that majority value.
- R4: A replica whose valid bit is 0 gets its fault bit set (omission). Bit i of `fault_mask` belongs to replica i.
- R5: A valid replica whose signature differs from the agreed value gets its fault bit set (commission). A valid replica that matches gets its bit cleared.
- R6: When no value reaches a strict majority, `majority_ok` is 0, `fault_mask` is all ones and `agreed_sig` is 0.
- R7: The signature lane of a replica whose valid bit is 0 casts no vote, even when it equals the values of other replicas.
- R8: While `start` is 0, input changes have no effect and all outputs hold their values.
- R9: A synchronous active-high reset drives `majority_ok` to 0, `fault_mask` to 0 and `agreed_sig` to 0.
- R10: Replica i's signature occupies bits [i*32 +: 32] of `rep_sig`, and its valid flag is bit i of `rep_valid`.
- R11: A split vote with no strict majority (for example 2-2-1 among five replicas) is reported as no majority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a vote |
| rep_valid | input | N | Per-replica report-present flag |
| rep_sig | input | N*32 | Packed replica signatures, replica i at [i*32 +: 32] |
| agreed_sig | output | 32 | Majority signature, or 0 when there is none |
| majority_ok | output | 1 | A strict majority was found |
| fault_mask | output | N | Per-replica fault flag |

## Verification
The checker assumes that `rep_valid` and `rep_sig` are settled and known whenever `start` is high. It also assumes that `start` is never high in a cycle where `rst` is high, so every vote begins from a clean reset. The bench applies new inputs and raises `start` only at the falling edge. It lowers `start` again at the next falling edge and pulses reset only while `start` is low. The properties therefore see each vote exactly once and never see a vote overlap a reset.

// File: rtl/voter_pkg.sv
package voter_pkg;

  // Smallest vote count that forms a strict majority of n replicas.
  function automatic int unsigned quorum(input int unsigned n);
    return n / 2 + 1;
  endfunction

  // Width needed to hold a count from 0 to n.
  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pair_match.sv
// For every replica, count how many valid replicas report the same signature.
module pair_match #(
  parameter int N  = 5,
  parameter int W  = 32,
  parameter int CW = 3
) (
  input  logic [N-1:0]   valid,
  input  logic [N*W-1:0] sigs,
  output logic [N*CW-1:0] counts
);

  for (genvar i = 0; i < N; i++) begin : g_row
    logic [CW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < N; j++) begin
        if (valid[i] && valid[j] && (sigs[i*W +: W] == sigs[j*W +: W]))
          acc = acc + 1'b1;
      end
    end
    assign counts[i*CW +: CW] = acc;
  end

endmodule

// File: rtl/winner_pick.sv
// Choose the lowest-index replica whose count reaches the quorum.
module winner_pick #(
  parameter int N  = 5,
  parameter int W  = 32,
  parameter int CW = 3
) (
  input  logic [N*CW-1:0] counts,
  input  logic [N*W-1:0]  sigs,
  output logic            found,
  output logic [W-1:0]    win_sig
);

  localparam logic [CW-1:0] QUORUM = CW'(voter_pkg::quorum(N));

  always_comb begin
    found   = 1'b0;
    win_sig = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (counts[i*CW +: CW] >= QUORUM) begin
        found   = 1'b1;
        win_sig = sigs[i*W +: W];
      end
    end
  end

endmodule

// File: rtl/fault_flag.sv
// Flag omission (no report) and commission (wrong value) per replica.
module fault_flag #(
  parameter int N = 5,
  parameter int W = 32
) (
  input  logic [N-1:0]   valid,
  input  logic [N*W-1:0] sigs,
  input  logic           found,
  input  logic [W-1:0]   win_sig,
  output logic [N-1:0]   mask
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign mask[i] = !found || !valid[i] || (sigs[i*W +: W] != win_sig);
  end

endmodule

// File: rtl/sig_majority_voter.sv
module sig_majority_voter #(
  parameter int N = 5,
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   rep_valid,
  input  logic [N*W-1:0] rep_sig,
  output logic [W-1:0]   agreed_sig,
  output logic           majority_ok,
  output logic [N-1:0]   fault_mask
);

  localparam int CW = voter_pkg::count_width(N);

  logic [N*CW-1:0] counts;
  logic            found;
  logic [W-1:0]    win_sig;
  logic [N-1:0]    mask_c;

  pair_match #(.N(N), .W(W), .CW(CW)) u_match (
    .valid (rep_valid),
    .sigs  (rep_sig),
    .counts(counts)
  );

  winner_pick #(.N(N), .W(W), .CW(CW)) u_pick (
    .counts (counts),
    .sigs   (rep_sig),
    .found  (found),
    .win_sig(win_sig)
  );

  fault_flag #(.N(N), .W(W)) u_flag (
    .valid  (rep_valid),
    .sigs   (rep_sig),
    .found  (found),
    .win_sig(win_sig),
    .mask   (mask_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      agreed_sig  <= '0;
      majority_ok <= 1'b0;
      fault_mask  <= '0;
    end else if (start) begin
      agreed_sig  <= win_sig;
      majority_ok <= found;
      fault_mask  <= mask_c;
    end
  end

endmodule

// File: rtl/sig_majority_voter_chk.sv
module sig_majority_voter_chk #(
  parameter int N = 5,
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [N-1:0]   rep_valid,
  input logic [N*W-1:0] rep_sig,
  input logic [W-1:0]   agreed_sig,
  input logic           majority_ok,
  input logic [N-1:0]   fault_mask
);

  logic all_same;
  always_comb begin
    all_same = 1'b1;
    for (int i = 1; i < N; i++)
      if (rep_sig[i*W +: W] != rep_sig[W-1:0]) all_same = 1'b0;
  end

  // R9: reset clears every output
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!majority_ok && fault_mask == '0 && agreed_sig == '0));

  // R8 / R1: without start, outputs hold
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(agreed_sig) && $stable(majority_ok) && $stable(fault_mask)));

  // R2: a majority means more than half the replicas are fault free
  a_r2_quorum: assert property (@(posedge clk) disable iff (rst)
    majority_ok |-> ($countones(~fault_mask) > N / 2));

  // R6: no majority means all replicas flagged and zero signature
  a_r6_no_majority: assert property (@(posedge clk) disable iff (rst)
    (start ##1 !majority_ok) |-> (fault_mask == '1 && agreed_sig == '0));

  // R4: an absent report is always flagged
  a_r4_omission: assert property (@(posedge clk) disable iff (rst)
    start |=> ((~$past(rep_valid) & ~fault_mask) == '0));

  // R5 / R3: unanimous full report gives a clean result
  a_r5_unanimous: assert property (@(posedge clk) disable iff (rst)
    (start && rep_valid == '1 && all_same) |=>
      (majority_ok && fault_mask == '0 && agreed_sig == $past(rep_sig[W-1:0])));

  // R7: with no valid report nothing can win
  a_r7_none_valid: assert property (@(posedge clk) disable iff (rst)
    (start && rep_valid == '0) |=> !majority_ok);

endmodule

bind sig_majority_voter sig_majority_voter_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/sig_majority_voter_tb.sv
`timescale 1ns/1ps
module sig_majority_voter_tb;

  localparam int N  = 5;
  localparam int W  = 32;
  localparam int NV = 9;

  localparam logic [W-1:0] A = 32'hA5A5_0001;
  localparam logic [W-1:0] B = 32'h1234_5678;
  localparam logic [W-1:0] C = 32'h0BAD_F00D;

  // Replica 4 is leftmost in each concatenation (R10 lane order).
  localparam logic [N*W-1:0] V_SIG [NV] = '{
    {A, A, A, A, A},
    {A, A, A, B, C},
    {B, B, A, A, C},
    {A, A, A, A, A},
    {A, A, A, A, A},
    {B, B, B, A, A},
    {C, C, C, C, B},
    {A, A, A, A, A},
    {A, B, A, C, A}
  };
  localparam logic [N-1:0] V_VAL [NV] = '{
    5'b11111, 5'b11111, 5'b11111, 5'b11100, 5'b11000,
    5'b00111, 5'b11110, 5'b00000, 5'b11111
  };
  localparam logic       V_OK  [NV] = '{1, 1, 0, 1, 0, 0, 1, 0, 1};
  localparam logic [W-1:0] V_AGR [NV] = '{A, A, 0, A, 0, 0, C, 0, A};
  localparam logic [N-1:0] V_MSK [NV] = '{
    5'b00000, 5'b00011, 5'b11111, 5'b00011, 5'b11111,
    5'b11111, 5'b00001, 5'b11111, 5'b01010
  };
  localparam string V_TAG [NV] = '{
    "R2 unanimous", "R5 commission", "R11 split vote", "R4 omission",
    "R6 too few valid", "R7 invalid lanes ignored", "R4 R5 mixed",
    "R7 none valid", "R10 lane positions"
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N-1:0]   rep_valid = '0;
  logic [N*W-1:0] rep_sig = '0;
  logic [W-1:0]   agreed_sig;
  logic           majority_ok;
  logic [N-1:0]   fault_mask;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sig_majority_voter #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .rep_valid(rep_valid),
    .rep_sig(rep_sig), .agreed_sig(agreed_sig),
    .majority_ok(majority_ok), .fault_mask(fault_mask)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic ok, input logic [W-1:0] sg,
                         input logic [N-1:0] mk);
    chk({tag, " ok"},   64'(majority_ok), 64'(ok));
    chk({tag, " sig"},  64'(agreed_sig),  64'(sg));
    chk({tag, " mask"}, 64'(fault_mask),  64'(mk));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic           p_ok;
    logic [W-1:0]   p_sig;
    logic [N-1:0]   p_msk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R9 reset state", 1'b0, '0, '0);
    p_ok = 1'b0; p_sig = '0; p_msk = '0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      rep_sig   = V_SIG[k];
      rep_valid = V_VAL[k];
      start     = 1'b1;
      #0.5;
      chk_out("R1 before edge", p_ok, p_sig, p_msk);
      @(negedge clk);
      start = 1'b0;
      chk_out(V_TAG[k], V_OK[k], V_AGR[k], V_MSK[k]);
      p_ok = V_OK[k]; p_sig = V_AGR[k]; p_msk = V_MSK[k];
    end

    // R8: inputs change without start; outputs must hold
    @(negedge clk);
    rep_sig   = {C, C, C, C, C};
    rep_valid = '1;
    repeat (3) @(negedge clk);
    chk_out("R8 hold", p_ok, p_sig, p_msk);

    // R3: a fresh vote after a held state picks up the new value
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_out("R3 new majority", 1'b1, C, 5'b00000);

    // R9: reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R9 reset clears", 1'b0, '0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule